// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequencies of a small clock tree from the control words that configure it. Every frequency starts from a 24 MHz reference. A system PLL multiplies the reference by 20 or 22. Two fractional outputs of the PLL scale its frequency by 18/frac. A mux picks the root clock from the PLL or one of those fractional outputs. Three divisors of the form (1 + field) then follow one after another and give the bus (AHB), interface (IPG) and peripheral clocks.

Software or another block presents the five control words and pulses `start`. The unit latches the fields it needs and runs up to four integer divisions on one shared iterative divider. It then publishes all five frequencies together and raises `done` for one cycle. A selected fraction field of zero is caught before it can reach the divider. No clocks are generated: the results are numbers only.

Top module: `clkfreq_calc`

## Requirements
- R1: After synchronous reset every frequency output, `frac_err` and `done` read 0.
- R2: The PLL frequency is 24,000,000 × 22 = 528,000,000 when bit 0 of `pll_ctrl` is 1, and 24,000,000 × 20 = 480,000,000 when it is 0.
- R3: The root select is `mux_ctrl[19:18]`. Fraction A is `frac_ctrl[5:0]` and fraction B is `frac_ctrl[21:16]`. The root frequency is:
  - select 0: the PLL frequency;
  - select 1: floor(PLL × 18 / B);
  - select 2: floor(PLL × 18 / A);
  - select 3: floor(floor(PLL × 18 / B) / 2).
- R4: The AHB frequency is floor(root / (1 + `bdiv_ctrl[12:10]`)).
- R5: The IPG frequency is floor(AHB / (1 + `bdiv_ctrl[9:8]`)).
- R6: The peripheral frequency is floor(IPG / (1 + `pdiv_ctrl[5:0]`)).
- R7: If the fraction field on the selected path is zero, the root, AHB, IPG and peripheral results are 0 and `frac_err` is 1. `frac_err` is 0 in every other case, including when the unselected fraction field is zero.
- R8: Internal values carry at least 40 bits. Any published result above 2^32−1 reads 0xFFFFFFFF. The stages after it divide the full-precision value, not the saturated one.
- R9: `done` is high for exactly one cycle. That is the cycle in which all five results and `frac_err` first show a new computation. Between `done` pulses the outputs hold their values.
- R10: Inputs are sampled only in the cycle where `start` is accepted. A `start` pulse during a computation is ignored, and so is any change to the control words during it. Neither one produces a second `done` pulse.
- R11: `done` follows an accepted `start` within 4×(W+3)+4 cycles, where W = 40 is the datapath width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| pll_ctrl | input | 32 | PLL control word; bit 0 picks the multiplier |
| frac_ctrl | input | 32 | Fractional divider word; fields [5:0] and [21:16] |
| mux_ctrl | input | 32 | Clock mux word; root select in [19:18] |
| bdiv_ctrl | input | 32 | Bus divider word; AHB field [12:10], IPG field [9:8] |
| pdiv_ctrl | input | 32 | Peripheral divider word; field [5:0] |
| pll_hz | output | 32 | PLL frequency |
| root_hz | output | 32 | Root clock frequency |
| ahb_hz | output | 32 | AHB clock frequency |
| ipg_hz | output | 32 | IPG clock frequency |
| per_hz | output | 32 | Peripheral clock frequency |
| frac_err | output | 1 | Selected fraction field was zero |
| done | output | 1 | One-cycle pulse when results are published |

## Verification
The results are published only when `done` pulses, so a wrong stage register or a divider mistake stays hidden until the end of the run that used it. It then appears at that `done` pulse as a wrong value on one output and on every stage after it in the chain. A stray publish, or a start accepted while busy, shows at the ports as an output that changes without `done`, or as an extra `done` pulse. The every-cycle comparison catches both in the cycle they occur. The fraction-of-one case checks saturation together with full-precision division on the path, so a stage that truncates too early gives a wrong AHB value at the very next `done`.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;
  localparam int unsigned REF_HZ     = 24_000_000;
  localparam int unsigned MUL_HI     = 22;
  localparam int unsigned MUL_LO     = 20;
  localparam int unsigned FRAC_SCALE = 18;

  // field positions decoded from the control words
  localparam int SEL_LSB  = 18;
  localparam int FA_LSB   = 0;
  localparam int FB_LSB   = 16;
  localparam int FRAC_W   = 6;
  localparam int AHB_LSB  = 10;
  localparam int AHB_W    = 3;
  localparam int IPG_LSB  = 8;
  localparam int IPG_W    = 2;
  localparam int PER_LSB  = 0;
  localparam int PER_W    = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROOT, ST_AHB, ST_IPG, ST_PER
  } calc_state_t;

  function automatic logic [31:0] sat32(input logic [63:0] v);
    return (v > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : v[31:0];
  endfunction
endpackage

// File: rtl/clkfreq_div.sv
module clkfreq_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         valid
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, diff;
  logic [W-1:0]  q_next, rem_next;

  always_comb begin
    shifted = {rem_q, q_q[W-1]};
    diff    = shifted - {1'b0, d_q};
    if (!diff[W]) begin
      rem_next = diff[W-1:0];
      q_next   = {q_q[W-2:0], 1'b1};
    end else begin
      rem_next = shifted[W-1:0];
      q_next   = {q_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    valid <= 1'b0;
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
      d_q   <= '0;
      quo   <= '0;
    end else if (go && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= CW'(W);
      rem_q <= '0;
      q_q   <= num;
      d_q   <= den;
    end else if (run_q) begin
      rem_q <= rem_next;
      q_q   <= q_next;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q <= 1'b0;
        valid <= 1'b1;
        quo   <= q_next;
      end
    end
  end
endmodule

// File: rtl/clkfreq_seq.sv
module clkfreq_seq
  import clkfreq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                pll_hi,
  input  logic [1:0]          root_sel,
  input  logic [FRAC_W-1:0]   frac_a,
  input  logic [FRAC_W-1:0]   frac_b,
  input  logic [AHB_W-1:0]    ahb_f,
  input  logic [IPG_W-1:0]    ipg_f,
  input  logic [PER_W-1:0]    per_f,
  output logic                div_go,
  output logic [W-1:0]        div_num,
  output logic [W-1:0]        div_den,
  input  logic [W-1:0]        div_quo,
  input  logic                div_valid,
  output logic [31:0]         pll_hz,
  output logic [31:0]         root_hz,
  output logic [31:0]         ahb_hz,
  output logic [31:0]         ipg_hz,
  output logic [31:0]         per_hz,
  output logic                frac_err,
  output logic                done
);
  calc_state_t        st_q;
  logic [W-1:0]       pll_q, root_q, ahb_q, ipg_q;
  logic [IPG_W-1:0]   ipg_f_q;
  logic [PER_W-1:0]   per_f_q;
  logic [AHB_W-1:0]   ahb_f_q;
  logic               half_q, err_q;

  logic [W-1:0]       pll_n, root_n;
  logic [FRAC_W-1:0]  frac_sel;

  always_comb begin
    pll_n    = W'(REF_HZ) * W'(pll_hi ? MUL_HI : MUL_LO);
    frac_sel = root_sel[0] ? frac_b : frac_a;
    root_n   = half_q ? (div_quo >> 1) : div_quo;
  end

  always_ff @(posedge clk) begin
    div_go <= 1'b0;
    done   <= 1'b0;
    if (rst) begin
      st_q     <= ST_IDLE;
      pll_q    <= '0; root_q <= '0; ahb_q <= '0; ipg_q <= '0;
      ipg_f_q  <= '0; per_f_q <= '0; ahb_f_q <= '0;
      half_q   <= 1'b0; err_q <= 1'b0;
      div_num  <= '0; div_den <= '0;
      pll_hz   <= '0; root_hz <= '0; ahb_hz <= '0; ipg_hz <= '0; per_hz <= '0;
      frac_err <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          pll_q   <= pll_n;
          ipg_f_q <= ipg_f;
          per_f_q <= per_f;
          ahb_f_q <= ahb_f;
          half_q  <= (root_sel == 2'd3);
          err_q   <= 1'b0;
          div_go  <= 1'b1;
          if (root_sel == 2'd0) begin
            root_q  <= pll_n;
            div_num <= pll_n;
            div_den <= W'(ahb_f) + W'(1);
            st_q    <= ST_AHB;
          end else if (frac_sel == '0) begin
            root_q  <= '0;
            err_q   <= 1'b1;
            div_num <= '0;
            div_den <= W'(ahb_f) + W'(1);
            st_q    <= ST_AHB;
          end else begin
            div_num <= pll_n * W'(FRAC_SCALE);
            div_den <= W'(frac_sel);
            st_q    <= ST_ROOT;
          end
        end
        ST_ROOT: if (div_valid) begin
          root_q  <= root_n;
          div_num <= root_n;
          div_den <= W'(ahb_f_q) + W'(1);
          div_go  <= 1'b1;
          st_q    <= ST_AHB;
        end
        ST_AHB: if (div_valid) begin
          ahb_q   <= div_quo;
          div_num <= div_quo;
          div_den <= W'(ipg_f_q) + W'(1);
          div_go  <= 1'b1;
          st_q    <= ST_IPG;
        end
        ST_IPG: if (div_valid) begin
          ipg_q   <= div_quo;
          div_num <= div_quo;
          div_den <= W'(per_f_q) + W'(1);
          div_go  <= 1'b1;
          st_q    <= ST_PER;
        end
        ST_PER: if (div_valid) begin
          pll_hz   <= sat32(64'(pll_q));
          root_hz  <= sat32(64'(root_q));
          ahb_hz   <= sat32(64'(ahb_q));
          ipg_hz   <= sat32(64'(ipg_q));
          per_hz   <= sat32(64'(div_quo));
          frac_err <= err_q;
          done     <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkfreq_calc.sv
module clkfreq_calc
  import clkfreq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] pll_ctrl,
  input  logic [31:0] frac_ctrl,
  input  logic [31:0] mux_ctrl,
  input  logic [31:0] bdiv_ctrl,
  input  logic [31:0] pdiv_ctrl,
  output logic [31:0] pll_hz,
  output logic [31:0] root_hz,
  output logic [31:0] ahb_hz,
  output logic [31:0] ipg_hz,
  output logic [31:0] per_hz,
  output logic        frac_err,
  output logic        done
);
  logic         div_go, div_valid;
  logic [W-1:0] div_num, div_den, div_quo;
  logic         unused_bits;

  assign unused_bits = ^{pll_ctrl[31:1], frac_ctrl[31:22], frac_ctrl[15:6],
                         mux_ctrl[31:20], mux_ctrl[17:0], bdiv_ctrl[31:13],
                         bdiv_ctrl[7:0], pdiv_ctrl[31:6]};

  clkfreq_seq #(.W(W)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .pll_hi(pll_ctrl[0]),
    .root_sel(mux_ctrl[SEL_LSB +: 2]),
    .frac_a(frac_ctrl[FA_LSB +: FRAC_W]),
    .frac_b(frac_ctrl[FB_LSB +: FRAC_W]),
    .ahb_f(bdiv_ctrl[AHB_LSB +: AHB_W]),
    .ipg_f(bdiv_ctrl[IPG_LSB +: IPG_W]),
    .per_f(pdiv_ctrl[PER_LSB +: PER_W]),
    .div_go(div_go), .div_num(div_num), .div_den(div_den),
    .div_quo(div_quo), .div_valid(div_valid),
    .pll_hz(pll_hz), .root_hz(root_hz), .ahb_hz(ahb_hz),
    .ipg_hz(ipg_hz), .per_hz(per_hz), .frac_err(frac_err), .done(done)
  );

  clkfreq_div #(.W(W)) div_i (
    .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
    .quo(div_quo), .valid(div_valid)
  );
endmodule

// File: rtl/clkfreq_calc_chk.sv
module clkfreq_calc_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pll_hz,
  input logic [31:0] root_hz,
  input logic [31:0] ahb_hz,
  input logic [31:0] ipg_hz,
  input logic [31:0] per_hz,
  input logic        frac_err,
  input logic        done
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pll_hz) && $stable(root_hz) && $stable(ahb_hz) &&
               $stable(ipg_hz) && $stable(per_hz) && $stable(frac_err)));

  p_pll_value_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (pll_hz == 32'd528_000_000 || pll_hz == 32'd480_000_000));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done && frac_err) |-> (root_hz == 0 && ahb_hz == 0 && ipg_hz == 0 && per_hz == 0));

  p_ahb_le_root_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (ahb_hz <= root_hz));

  p_chain_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (ipg_hz <= ahb_hz));

  p_chain_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (per_hz <= ipg_hz));
endmodule

bind clkfreq_calc clkfreq_calc_chk chk_i (.*);

// File: tb/clkfreq_calc_tb.sv
module clkfreq_calc_tb_top;
  localparam int W = 40;
  localparam int LAT_MAX = 4 * (W + 3) + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] pll_ctrl = '0, frac_ctrl = '0, mux_ctrl = '0, bdiv_ctrl = '0, pdiv_ctrl = '0;
  logic [31:0] pll_hz, root_hz, ahb_hz, ipg_hz, per_hz;
  logic frac_err, done;

  int checks = 0;
  int errors = 0;
  bit waiting = 0;
  bit started = 0;
  longint e_pll = 0, e_root = 0, e_ahb = 0, e_ipg = 0, e_per = 0;
  bit e_err = 0;

  always #10 clk = ~clk;

  clkfreq_calc #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .pll_ctrl(pll_ctrl), .frac_ctrl(frac_ctrl), .mux_ctrl(mux_ctrl),
    .bdiv_ctrl(bdiv_ctrl), .pdiv_ctrl(pdiv_ctrl),
    .pll_hz(pll_hz), .root_hz(root_hz), .ahb_hz(ahb_hz), .ipg_hz(ipg_hz),
    .per_hz(per_hz), .frac_err(frac_err), .done(done)
  );

  function automatic longint sat(input longint v);
    return (v > 64'sh0_FFFF_FFFF) ? 64'sh0_FFFF_FFFF : v;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference of the clock tree
  task automatic model(input logic [31:0] p, f, m, b, d);
    longint pll, root, fa, fb, sel;
    bit err;
    pll  = 24_000_000 * (p[0] ? 22 : 20);
    sel  = m[19:18];
    fa   = f[5:0];
    fb   = f[21:16];
    err  = 0;
    root = 0;
    case (sel)
      0: root = pll;
      1: if (fb == 0) err = 1; else root = pll * 18 / fb;
      2: if (fa == 0) err = 1; else root = pll * 18 / fa;
      default: if (fb == 0) err = 1; else root = (pll * 18 / fb) / 2;
    endcase
    e_pll  = sat(pll);
    e_root = sat(root);
    e_ahb  = root / (1 + b[12:10]);
    e_ipg  = e_ahb / (1 + b[9:8]);
    e_per  = sat(e_ipg / (1 + d[5:0]));
    e_ipg  = sat(e_ipg);
    e_ahb  = sat(e_ahb);
    e_err  = err;
  endtask

  // every-cycle comparison against the last published result set
  always @(negedge clk) begin
    if (!rst) begin
      if (done && !waiting) begin
        checks++; errors++;
        $display("FAIL R10 unexpected done pulse: actual 1 expected 0");
      end
      if (!done && started) begin
        checks++;
        if (pll_hz != e_pll[31:0] || root_hz != e_root[31:0] || ahb_hz != e_ahb[31:0] ||
            ipg_hz != e_ipg[31:0] || per_hz != e_per[31:0] || frac_err != e_err) begin
          errors++;
          $display("FAIL R9 outputs moved without done: actual per %0d expected %0d", per_hz, e_per);
        end
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] p, f, m, b, d, input bit busy_poke);
    int lat;
    @(negedge clk);
    pll_ctrl = p; frac_ctrl = f; mux_ctrl = m; bdiv_ctrl = b; pdiv_ctrl = d;
    start = 1'b1;
    waiting = 1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    // R10: disturb inputs and start again mid-run
    if (busy_poke) begin
      repeat (5) @(negedge clk);
      lat += 5;
      pll_ctrl = ~p; frac_ctrl = 32'h0; mux_ctrl = 32'h0008_0000;
      bdiv_ctrl = 32'h1C00; pdiv_ctrl = 32'h3F;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    while (!done && lat <= LAT_MAX) begin
      @(negedge clk);
      lat++;
    end
    chk("R11", {tag, " done latency in bound"}, longint'(lat <= LAT_MAX), 1);
    model(p, f, m, b, d);
    started = 1;
    chk("R2", {tag, " pll"}, pll_hz, e_pll);
    chk("R3", {tag, " root"}, root_hz, e_root);
    chk("R4", {tag, " ahb"}, ahb_hz, e_ahb);
    chk("R5", {tag, " ipg"}, ipg_hz, e_ipg);
    chk("R6", {tag, " per"}, per_hz, e_per);
    chk("R7", {tag, " frac_err"}, frac_err, e_err);
    @(negedge clk);
    waiting = 0;
    chk("R9", {tag, " done single cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs", {pll_hz, root_hz, ahb_hz, ipg_hz, per_hz} == '0, 1);
    chk("R1", "reset done/err", {done, frac_err}, 0);

    run("pll-direct", 32'h1, 32'h0, 32'h0, (3 << 10) | (1 << 8), 32'h0, 0);
    run("fracB",      32'h0, (35 << 16), (1 << 18), (0 << 10) | (3 << 8), 32'd63, 0);
    run("fracA",      32'h1, 32'd24, (2 << 18), (2 << 10) | (2 << 8), 32'd5, 0);
    run("fracB-half", 32'h1, (29 << 16) | 32'd3, (3 << 18), (1 << 10), 32'd1, 0);
    run("zeroB-R7",   32'h1, 32'd17, (1 << 18), 32'h0, 32'h0, 0);
    run("zeroA-R7",   32'h0, (20 << 16), (2 << 18), (1 << 10), 32'h0, 0);
    run("sat-R8",     32'h1, 32'd1, (2 << 18), (7 << 10) | (3 << 8), 32'd2, 0);
    run("busy-R10",   32'h0, (12 << 16), (3 << 18), (4 << 10) | (1 << 8), 32'd9, 1);
    repeat (LAT_MAX + 20) @(negedge clk);
    chk("R10", "no extra done after busy start", done, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule